// File: doc/BRIEF.md
# Link Detect Substate Controller

This block runs the detect phase of a serial link training sequencer. It alternates between a quiet substate, where the transmit lines are left to settle, and an active substate, where it asks the PHY for one receiver-detection operation. The quiet substate ends in one of two ways:

- a fixed 12 ms timeout expires, or
- a lane that belongs to the link leaves electrical idle, but only once a programmable minimum dwell has passed.

Lanes not assigned to the link are masked so that they always read as idle. Without this mask, a lane handed to some other protocol could cut the quiet substate short.

The active substate holds the detect request until the PHY reports completion. If no receiver is found, the block returns to the quiet substate and serves a fresh dwell. Two detect operations therefore never run back-to-back. If a receiver is found, the block pulses an advance strobe and parks in a polling state until a restart or a reset.

Time is counted in clock cycles. The parameter `CLK_FREQ_MHZ` sets the number of cycles per microsecond. At the default of 1, the timeout is 12000 cycles and the minimum dwells are 0, 100, 1000 and 2000 cycles.

Top module: `link_detect_ctrl`

## Requirements
- R1: After a synchronous reset, `state_o` is 2'b00 (quiet), `det_req_o` is 0 and `advance_o` is 0.
- R2: With no qualifying idle exit, the quiet substate lasts exactly 12000×CLK_FREQ_MHZ cycles, then `state_o` becomes 2'b01 (active).
- R3: The quiet cycles are numbered from 0 starting at entry. `min_code_i` gives the minimum M in µs: 2'b00 gives 0, 2'b01 gives 100, 2'b10 gives 1000 and 2'b11 gives 2000. An idle exit held throughout makes the quiet substate last exactly M×CLK_FREQ_MHZ+1 cycles.
- R4: An idle exit that goes away before the minimum dwell has elapsed does not end the quiet substate.
- R5: `eidle_i` bit n is 1 when lane n is idle. Only a lane with `lane_en_i` bit n set to 1 can signal an idle exit. Unassigned lanes read as idle whatever their raw value.
- R6: `det_req_o` is 1 in every cycle the block is in the active substate, and it stays 1 until `det_done_i` is seen.
- R7: When `det_done_i` is 1 and `rx_present_i` is 0 in the active substate, the next cycle shows quiet with `det_req_o` at 0. A complete new minimum dwell is then served before the next detect.
- R8: When `det_done_i` and `rx_present_i` are both 1 in the active substate, the next cycle shows `state_o` at 2'b10 (polling) and `advance_o` at 1 for that single cycle. The polling state holds until restart.
- R9: `det_done_i` and `rx_present_i` have no effect outside the active substate.
- R10: `restart_i` moves the block to quiet from any state on the next cycle, with the dwell count cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| restart_i | input | 1 | Return to quiet and clear the dwell count |
| eidle_i | input | LANES | Raw per-lane electrical-idle status, 1 = idle |
| lane_en_i | input | LANES | Lane belongs to this link when 1 |
| min_code_i | input | 2 | Minimum quiet dwell code |
| det_done_i | input | 1 | Receiver detection finished |
| rx_present_i | input | 1 | Receiver found; valid while det_done_i is 1 |
| state_o | output | 2 | Substate: 00 quiet, 01 active, 10 polling |
| det_req_o | output | 1 | Receiver-detect request to the PHY |
| advance_o | output | 1 | One-cycle pulse on entry to polling |

## Verification
The hardest case to reach is an idle exit that arrives early in the dwell and then disappears. This must not end the quiet substate, while a later exit, once the minimum has passed, must end it. The stimulus uses a restart to zero the dwell count at a known cycle. It then raises an exit on an assigned lane well inside the 100-cycle minimum and drops it again. After that it raises an exit on an unassigned lane past the minimum and checks that quiet still holds. Finally it raises an exit on the assigned lane and expects the transition on the next cycle. A failed detect followed by a measured second dwell shows that the back-to-back case is avoided.

// File: rtl/ldc_pkg.sv
package ldc_pkg;

  typedef enum logic [1:0] {
    ST_QUIET  = 2'b00,
    ST_ACTIVE = 2'b01,
    ST_POLL   = 2'b10
  } det_state_e;

  localparam int unsigned TIMEOUT_US = 12000;

  // minimum quiet dwell in microseconds for each 2-bit code
  function automatic int unsigned min_dwell_us(input logic [1:0] code);
    case (code)
      2'b01:   return 100;
      2'b10:   return 1000;
      2'b11:   return 2000;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/lane_exit_detect.sv
module lane_exit_detect #(
  parameter int LANES = 4
) (
  input  logic [LANES-1:0] eidle_i,
  input  logic [LANES-1:0] lane_en_i,
  output logic             exit_any_o
);

  logic [LANES-1:0] seen_idle;

  // an unassigned lane is forced to read as idle
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign seen_idle[g] = eidle_i[g] | ~lane_en_i[g];
  end

  assign exit_any_o = ~(&seen_idle);

endmodule

// File: rtl/dwell_timer.sv
module dwell_timer #(
  parameter int CLK_FREQ_MHZ = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       stay_i,
  input  logic [1:0] code_i,
  output logic       min_met_o,
  output logic       timed_out_o
);
  import ldc_pkg::*;

  localparam int unsigned TIMEOUT_CYC = TIMEOUT_US * CLK_FREQ_MHZ;
  localparam int          CNT_W       = $clog2(TIMEOUT_CYC);
  localparam int unsigned LAST        = TIMEOUT_CYC - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] min_cyc;

  always_comb begin
    min_cyc = CNT_W'(min_dwell_us(code_i) * CLK_FREQ_MHZ);
  end

  // one counter serves both the minimum and the timeout
  always_ff @(posedge clk) begin
    if (rst)                                cnt_q <= '0;
    else if (stay_i && cnt_q != CNT_W'(LAST)) cnt_q <= cnt_q + 1'b1;
    else if (!stay_i)                       cnt_q <= '0;
  end

  assign min_met_o   = (cnt_q >= min_cyc);
  assign timed_out_o = (cnt_q == CNT_W'(LAST));

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(LAST)); // R2

  AST_TIMEOUT_HAS_MIN: assert property (@(posedge clk) disable iff (rst)
    timed_out_o |-> min_met_o); // R3

endmodule

// File: rtl/detect_seq.sv
module detect_seq (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart_i,
  input  logic              exit_any_i,
  input  logic              min_met_i,
  input  logic              timed_out_i,
  input  logic              done_i,
  input  logic              present_i,
  output ldc_pkg::det_state_e state_o,
  output logic              req_o,
  output logic              adv_o,
  output logic              stay_o
);
  import ldc_pkg::*;

  det_state_e state_q, nxt;
  logic       req_q, adv_q;

  always_comb begin
    nxt = state_q;
    case (state_q)
      ST_QUIET:  if (timed_out_i || (min_met_i && exit_any_i)) nxt = ST_ACTIVE;
      ST_ACTIVE: if (done_i) nxt = present_i ? ST_POLL : ST_QUIET;
      ST_POLL:   nxt = ST_POLL;
      default:   nxt = ST_QUIET;
    endcase
    if (restart_i) nxt = ST_QUIET;
  end

  assign stay_o = (state_q == ST_QUIET) && (nxt == ST_QUIET) && !restart_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_QUIET;
      req_q   <= 1'b0;
      adv_q   <= 1'b0;
    end else begin
      state_q <= nxt;
      req_q   <= (nxt == ST_ACTIVE);
      adv_q   <= (state_q == ST_ACTIVE) && done_i && present_i && !restart_i;
    end
  end

  assign state_o = state_q;
  assign req_o   = req_q;
  assign adv_o   = adv_q;

  AST_NO_EARLY_EXIT: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_QUIET && !min_met_i) |=> (state_q != ST_ACTIVE)); // R4

  AST_TIMEOUT_EXIT: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_QUIET && timed_out_i && !restart_i) |=> (state_q == ST_ACTIVE)); // R2

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (req_q && !done_i && !restart_i) |=> req_q); // R6

  AST_FAIL_RETURN: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ACTIVE && done_i && !present_i && !restart_i)
      |=> (state_q == ST_QUIET && !req_q)); // R7

  AST_ADV_PULSE: assert property (@(posedge clk) disable iff (rst)
    adv_q |=> !adv_q); // R8

  AST_ADV_IN_POLL: assert property (@(posedge clk) disable iff (rst)
    adv_q |-> (state_q == ST_POLL)); // R8

  AST_POLL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_POLL && !restart_i) |=> (state_q == ST_POLL)); // R8

  AST_RESTART: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> (state_q == ST_QUIET)); // R10

endmodule

// File: rtl/link_detect_ctrl.sv
module link_detect_ctrl #(
  parameter int LANES        = 4,
  parameter int CLK_FREQ_MHZ = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart_i,
  input  logic [LANES-1:0] eidle_i,
  input  logic [LANES-1:0] lane_en_i,
  input  logic [1:0]       min_code_i,
  input  logic             det_done_i,
  input  logic             rx_present_i,
  output logic [1:0]       state_o,
  output logic             det_req_o,
  output logic             advance_o
);
  import ldc_pkg::*;

  logic       exit_any, min_met, timed_out, stay;
  det_state_e st;

  lane_exit_detect #(.LANES(LANES)) u_mask (
    .eidle_i    (eidle_i),
    .lane_en_i  (lane_en_i),
    .exit_any_o (exit_any)
  );

  dwell_timer #(.CLK_FREQ_MHZ(CLK_FREQ_MHZ)) u_timer (
    .clk         (clk),
    .rst         (rst),
    .stay_i      (stay),
    .code_i      (min_code_i),
    .min_met_o   (min_met),
    .timed_out_o (timed_out)
  );

  detect_seq u_seq (
    .clk         (clk),
    .rst         (rst),
    .restart_i   (restart_i),
    .exit_any_i  (exit_any),
    .min_met_i   (min_met),
    .timed_out_i (timed_out),
    .done_i      (det_done_i),
    .present_i   (rx_present_i),
    .state_o     (st),
    .req_o       (det_req_o),
    .adv_o       (advance_o),
    .stay_o      (stay)
  );

  assign state_o = st;

  AST_REQ_MATCHES_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    det_req_o == (state_o == 2'b01)); // R6

  AST_ONLY_ASSIGNED: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'b00 && ((~eidle_i & lane_en_i) == '0) && !timed_out && !restart_i)
      |=> (state_o != 2'b01)); // R5

endmodule

// File: tb/link_detect_ctrl_tb_top.sv
`timescale 1ns/1ps
module link_detect_ctrl_tb_top;

  localparam int LANES = 4;
  localparam logic [1:0] S_QUIET = 2'b00, S_ACT = 2'b01, S_POLL = 2'b10;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             restart_i = 1'b0;
  logic [LANES-1:0] eidle_i = '1;
  logic [LANES-1:0] lane_en_i = '1;
  logic [1:0]       min_code_i = 2'b00;
  logic             det_done_i = 1'b0;
  logic             rx_present_i = 1'b0;
  logic [1:0]       state_o;
  logic             det_req_o;
  logic             advance_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  link_detect_ctrl #(.LANES(LANES), .CLK_FREQ_MHZ(1)) dut_i (
    .clk(clk), .rst(rst), .restart_i(restart_i), .eidle_i(eidle_i),
    .lane_en_i(lane_en_i), .min_code_i(min_code_i), .det_done_i(det_done_i),
    .rx_present_i(rx_present_i), .state_o(state_o), .det_req_o(det_req_o),
    .advance_o(advance_o)
  );

  // {code, lane_en, eidle, expected quiet length}
  localparam logic [25:0] VEC [6] = '{
    {2'b00, 4'b0011, 4'b1110, 16'd1},
    {2'b01, 4'b0011, 4'b1101, 16'd101},
    {2'b10, 4'b0001, 4'b1110, 16'd1001},
    {2'b11, 4'b0011, 4'b0011, 16'd12000},
    {2'b11, 4'b1111, 4'b0111, 16'd2001},
    {2'b00, 4'b0000, 4'b0000, 16'd12000}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk) rst = 1'b0;
  endtask

  // called at a negedge where quiet was just entered with count 0
  task automatic measure_quiet(output int len);
    int n = 0;
    for (int k = 0; k < 13000; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (state_o != S_QUIET) break;
      n++;
    end
    len = n + 1;
  endtask

  initial begin
    int len;
    for (int i = 0; i < 6; i++) begin
      min_code_i = VEC[i][25:24];
      lane_en_i  = VEC[i][23:20];
      eidle_i    = VEC[i][19:16];
      do_reset();
      if (i == 0) begin
        chk(state_o == S_QUIET, "R1 state", state_o, S_QUIET);
        chk(det_req_o == 1'b0, "R1 req", det_req_o, 0);
        chk(advance_o == 1'b0, "R1 advance", advance_o, 0);
      end
      measure_quiet(len);
      chk(len == int'(VEC[i][15:0]), "R2/R3/R5 quiet length", len, VEC[i][15:0]);
      chk(state_o == S_ACT && det_req_o, "R6 request on entry", det_req_o, 1);
      repeat (3) @(negedge clk);
      chk(state_o == S_ACT && det_req_o, "R6 request held", det_req_o, 1);
      det_done_i = 1'b1; rx_present_i = 1'b1;
      @(negedge clk);
      det_done_i = 1'b0; rx_present_i = 1'b0;
      chk(state_o == S_POLL, "R8 polling", state_o, S_POLL);
      chk(advance_o == 1'b1, "R8 advance high", advance_o, 1);
      @(negedge clk);
      chk(advance_o == 1'b0 && state_o == S_POLL, "R8 advance one cycle", advance_o, 0);
    end

    // polling is terminal: inputs do not move it (R8, R9)
    eidle_i = 4'b0000; lane_en_i = 4'b1111;
    det_done_i = 1'b1; rx_present_i = 1'b1;
    repeat (5) @(negedge clk);
    det_done_i = 1'b0; rx_present_i = 1'b0;
    chk(state_o == S_POLL && !advance_o, "R8 polling holds", state_o, S_POLL);

    // restart from polling, fresh dwell (R10)
    min_code_i = 2'b10; lane_en_i = 4'b0001; eidle_i = 4'b1110;
    restart_i = 1'b1;
    @(negedge clk) restart_i = 1'b0;
    chk(state_o == S_QUIET, "R10 restart to quiet", state_o, S_QUIET);
    measure_quiet(len);
    chk(len == 1001, "R10 count cleared", len, 1001);

    // failed detect returns to quiet and serves a fresh dwell (R7)
    det_done_i = 1'b1; rx_present_i = 1'b0;
    @(negedge clk) det_done_i = 1'b0;
    chk(state_o == S_QUIET && !det_req_o, "R7 back to quiet", state_o, S_QUIET);
    measure_quiet(len);
    chk(len == 1001, "R7 fresh dwell", len, 1001);

    // done ignored while quiet (R9)
    eidle_i = 4'b1111;
    det_done_i = 1'b1; rx_present_i = 1'b0;
    @(negedge clk) det_done_i = 1'b0;
    chk(state_o == S_QUIET, "R7 second failure", state_o, S_QUIET);
    det_done_i = 1'b1; rx_present_i = 1'b1;
    @(negedge clk);
    det_done_i = 1'b0; rx_present_i = 1'b0;
    @(negedge clk);
    chk(state_o == S_QUIET && !advance_o, "R9 done ignored in quiet", state_o, S_QUIET);

    // early exit that goes away is ignored (R4); unassigned lane ignored (R5)
    min_code_i = 2'b01; lane_en_i = 4'b0001; eidle_i = 4'b1111;
    restart_i = 1'b1;
    @(negedge clk) restart_i = 1'b0;
    repeat (10) @(negedge clk);
    eidle_i = 4'b1110;
    repeat (20) @(negedge clk);
    eidle_i = 4'b1111;
    repeat (120) @(negedge clk);
    chk(state_o == S_QUIET, "R4 early exit ignored", state_o, S_QUIET);
    eidle_i = 4'b0111;
    repeat (10) @(negedge clk);
    chk(state_o == S_QUIET, "R5 unassigned lane ignored", state_o, S_QUIET);
    eidle_i = 4'b1110;
    @(negedge clk);
    chk(state_o == S_ACT, "R3 exit after minimum", state_o, S_ACT);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule